// File: doc/BRIEF.md
# Dynamic Two-Input Bitwise Lookup Unit

This execution unit applies any two-input bitwise function to a pair of 64-bit operands, A and B. The function is not fixed by an immediate. It is a 4-entry truth table taken at issue time from one nibble of a third 64-bit operand, C. A single half-select input decides which of the two lowest nibbles of C supplies the table. Each of the 64 bit positions is evaluated on its own: bit i of A and bit i of B form a 2-bit index into the table, and the entry found there becomes bit i of the result.

An operation is issued by raising `in_valid` for one clock with the operands, C and the half-select present. The result appears, registered, on the next clock with `out_valid` high. Issues may arrive on every cycle. A new table or half-select value applies to the very operation it is issued with. No flags or condition bits are produced.

Control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_OUT` means the result register holds the output of the operation issued on the previous cycle. The transitions are: ISSUE (`ST_IDLE` to `ST_OUT` on `in_valid`), STREAM (`ST_OUT` to `ST_OUT` on `in_valid`) and DRAIN (`ST_OUT` to `ST_IDLE` without `in_valid`). Without `in_valid`, `ST_IDLE` stays in `ST_IDLE`.

Top module: `dyn_binlut`

## Requirements
- R1: While `rst_n` is low and directly after reset, `out_valid` is 0 and `out_result` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 after a cycle with `in_valid` low.
- R3: When `half_sel` is 0, the table is `op_c[3:0]` (LSB-0 numbering). Changing `op_c[63:4]` does not change the result.
- R4: When `half_sel` is 1, the table is `op_c[7:4]`. Changing `op_c[3:0]` or `op_c[63:8]` does not change the result.
- R5: Take the selected nibble N, with N[3] as its most significant bit. Result bit i is N[3] for (A_i,B_i)=(0,0), N[2] for (0,1), N[1] for (1,0) and N[0] for (1,1).
- R6: Every one of the 16 table values gives the matching function under both half-select settings, across varied operand patterns. Examples: 0001 gives A AND B, 0110 gives A XOR B, 0000 gives all zeros and 1111 gives all ones.
- R7: After a cycle with `in_valid` low, `out_result` keeps its previous value, whatever the inputs are.
- R8: Back-to-back issues that change `half_sel` or `op_c` from one cycle to the next each use their own table. No table value carries over from an earlier issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the operands on this cycle |
| op_a | input | 64 | Operand A, high bit of each lane's index |
| op_b | input | 64 | Operand B, low bit of each lane's index |
| op_c | input | 64 | Table-source register |
| half_sel | input | 1 | 0: table from bits 3..0 of op_c; 1: table from bits 7..4 |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 64 | Registered result |

## Verification
The checker module watches, on every cycle, the one-cycle valid timing, that the result holds between issues, and four fixed tables (constant zero, constant one, AND, XOR) picked through either half-select setting. It compares these against operands captured a cycle earlier. Only the bench scenarios show the other twelve tables, the exact lane index order, and that the unselected nibble and the upper bits of C have no effect. The bench covers these by sweeping all tables in both halves with decoy values in the unused nibble, then repeating issues with only the ignored bits changed.

// File: rtl/dlut_pkg.sv
package dlut_pkg;
    localparam int unsigned DLUT_XLEN  = 64;
    localparam int unsigned DLUT_NIB_W = 4;
    localparam int unsigned DLUT_HALVES = 2;

    typedef logic [DLUT_NIB_W-1:0] dlut_tbl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } dlut_state_e;
endpackage

// File: rtl/dlut_nib_sel.sv
module dlut_nib_sel
    import dlut_pkg::*;
#(
    parameter int unsigned XLEN   = DLUT_XLEN,
    parameter int unsigned HALVES = DLUT_HALVES
) (
    input  logic [XLEN-1:0] src,
    input  logic            half,
    output dlut_tbl_t       tbl
);
    localparam int unsigned SPAN = HALVES * DLUT_NIB_W;

    dlut_tbl_t cand [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_cand
        assign cand[h] = src[h*DLUT_NIB_W +: DLUT_NIB_W];
    end

    logic unused_hi;
    assign unused_hi = ^src[XLEN-1:SPAN];

    always_comb begin
        tbl = cand[0];
        if (half) begin
            tbl = cand[1];
        end
    end
endmodule

// File: rtl/dlut_lane_array.sv
module dlut_lane_array
    import dlut_pkg::*;
#(
    parameter int unsigned XLEN = DLUT_XLEN
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  dlut_tbl_t       tbl,
    output logic [XLEN-1:0] res
);
    for (genvar i = 0; i < XLEN; i++) begin : g_lane
        logic [1:0] idx;
        assign idx    = {a[i], b[i]};
        // entry order runs from the nibble's top bit down
        assign res[i] = tbl[~idx];
    end
endmodule

// File: rtl/dyn_binlut.sv
module dyn_binlut
    import dlut_pkg::*;
#(
    parameter int unsigned XLEN = DLUT_XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] op_c,
    input  logic            half_sel,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    dlut_state_e     state_q, state_d;
    dlut_tbl_t       tbl;
    logic [XLEN-1:0] lane_res;
    logic [XLEN-1:0] res_q;

    dlut_nib_sel #(.XLEN(XLEN), .HALVES(DLUT_HALVES)) u_sel (
        .src  (op_c),
        .half (half_sel),
        .tbl  (tbl)
    );

    dlut_lane_array #(.XLEN(XLEN)) u_lanes (
        .a   (op_a),
        .b   (op_b),
        .tbl (tbl),
        .res (lane_res)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_OUT;   // ISSUE
            ST_OUT:  if (!in_valid) state_d = ST_IDLE;  // DRAIN, else STREAM
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (in_valid) begin
            res_q <= lane_res;
        end
    end

    assign out_valid  = (state_q == ST_OUT);
    assign out_result = res_q;
endmodule

// File: rtl/dyn_binlut_chk.sv
module dyn_binlut_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] op_b,
    input logic [XLEN-1:0] op_c,
    input logic            half_sel,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result
);
    logic [3:0] pick;
    assign pick = half_sel ? op_c[7:4] : op_c[3:0];

    a_r2_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_no_valid_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    a_r6_table_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pick == 4'b0000) |=> (out_result == '0));

    a_r6_table_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pick == 4'b1111) |=> (out_result == '1));

    a_r5_table_and: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pick == 4'b0001) |=> (out_result == $past(op_a & op_b)));

    a_r5_table_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pick == 4'b0110) |=> (out_result == $past(op_a ^ op_b)));

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!out_valid && out_result == '0);
        end
    end
endmodule

bind dyn_binlut dyn_binlut_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .op_c       (op_c),
    .half_sel   (half_sel),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/dyn_binlut_bench.sv
module dyn_binlut_bench;
    localparam int unsigned W = 64;

    localparam logic [W-1:0] PAT_A [4] = '{
        64'h0000_0000_FFFF_FFFF, 64'hF0F0_F0F0_F0F0_F0F0,
        64'hDEAD_BEEF_0123_4567, 64'hAAAA_AAAA_AAAA_AAAA};
    localparam logic [W-1:0] PAT_B [4] = '{
        64'h0000_FFFF_0000_FFFF, 64'hCCCC_CCCC_CCCC_CCCC,
        64'h89AB_CDEF_FEED_F00D, 64'h5555_5555_5555_5555};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic         half_sel = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_result;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dyn_binlut u_dyn_binlut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .half_sel(half_sel),
        .out_valid(out_valid), .out_result(out_result));

    function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] n);
        return (~a & ~b & {W{n[3]}}) | (~a & b & {W{n[2]}}) |
               (a & ~b & {W{n[1]}})  | (a & b & {W{n[0]}});
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic h, input logic [W-1:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        in_valid = 1'b1; half_sel = h; op_c = c; op_a = a; op_b = b;
    endtask

    initial begin
        logic [W-1:0] held;
        repeat (2) @(negedge clk);
        chk("R1 valid in reset", {63'b0, out_valid}, '0);
        chk("R1 result in reset", out_result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {63'b0, out_valid}, '0);
        chk("R1 result after reset", out_result, '0);

        // R6/R3/R4/R8: all tables, both halves, decoy nibble and upper bits
        for (int h = 0; h < 2; h++) begin
            for (int t = 0; t < 16; t++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [3:0] tn, dn;
                    logic [W-1:0] c;
                    tn = 4'(t);
                    dn = ~tn;
                    c = {56'hA5C3_5A3C_9669_E1, (h == 1) ? {tn, dn} : {dn, tn}};
                    drive(h[0], c, PAT_A[p], PAT_B[p]);
                    @(negedge clk);
                    chk("R2 valid after issue", {63'b0, out_valid}, 64'd1);
                    chk("R6 sweep result", out_result, model(PAT_A[p], PAT_B[p], tn));
                end
            end
        end

        // R7: hold with inputs wiggling
        in_valid = 1'b0;
        held = out_result;
        op_a = ~op_a; op_c = ~op_c; half_sel = ~half_sel;
        @(negedge clk);
        chk("R2 valid drops", {63'b0, out_valid}, '0);
        chk("R7 hold 1", out_result, held);
        op_b = ~op_b;
        @(negedge clk);
        chk("R7 hold 2", out_result, held);

        // R3: half 0, upper bits of C changed
        drive(1'b0, {60'h0, 4'b0110}, PAT_A[2], PAT_B[2]);
        @(negedge clk);
        chk("R3 low nibble xor", out_result, PAT_A[2] ^ PAT_B[2]);
        drive(1'b0, {60'hFFFF_FFFF_FFFF_FFF, 4'b0110}, PAT_A[2], PAT_B[2]);
        @(negedge clk);
        chk("R3 upper bits ignored", out_result, PAT_A[2] ^ PAT_B[2]);

        // R4: half 1, low nibble and upper bits changed
        drive(1'b1, {56'h0, 4'b0001, 4'b0000}, PAT_A[1], PAT_B[1]);
        @(negedge clk);
        chk("R4 second nibble and", out_result, PAT_A[1] & PAT_B[1]);
        drive(1'b1, {56'hFF_FFFF_FFFF_FFFF, 4'b0001, 4'b1111}, PAT_A[1], PAT_B[1]);
        @(negedge clk);
        chk("R4 other bits ignored", out_result, PAT_A[1] & PAT_B[1]);

        // R8: same C, half flips each cycle
        drive(1'b1, 64'h1E, PAT_A[3], PAT_B[0]);
        @(negedge clk);
        chk("R8 half1 and", out_result, PAT_A[3] & PAT_B[0]);
        drive(1'b0, 64'h1E, PAT_A[3], PAT_B[0]);
        @(negedge clk);
        chk("R8 half0 nand", out_result, ~(PAT_A[3] & PAT_B[0]));

        // R5: single-entry tables pin down lane index order
        drive(1'b0, 64'h8, 64'h3, 64'h5);
        @(negedge clk);
        chk("R5 entry 00 at top bit", out_result, {{60{1'b1}}, 4'b1000});
        drive(1'b0, 64'h4, 64'h3, 64'h5);
        @(negedge clk);
        chk("R5 entry 01", out_result, 64'h4);
        drive(1'b0, 64'h2, 64'h3, 64'h5);
        @(negedge clk);
        chk("R5 entry 10", out_result, 64'h2);
        drive(1'b0, 64'h1, 64'h3, 64'h5);
        @(negedge clk);
        chk("R5 entry 11", out_result, 64'h1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 valid after last", {63'b0, out_valid}, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule